// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block is a synchronous front end for an external asynchronous static RAM holding 131,072 bytes. The RAM has a 17-bit address and an 8-bit data bus that it shares with the controller. A host on the system clock issues one single-byte read or write at a time through a request strobe. It sees a ready flag while the controller can accept work. It gets back a one-cycle completion pulse, and on reads the fetched byte.

The RAM has a low-true select, a high-true select, a low-true output enable and a low-true write enable. The controller drives all of them from registers, so they never glitch. Every nanosecond minimum of the RAM is turned into a cycle count for the configured clock period by rounding up. Writes are timed by the write enable while the output enable stays low. The shared data bus is split into an output value, a driver enable and an input value. The controller turns its driver on only once the RAM's output float time has passed. Between accesses the RAM is deselected long enough for its drivers to float.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, and whenever `host_ready` is high, `ram_sel_n`=1, `ram_sel`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0 and `host_done`=0.
- R2: A read holds both selects active, `ram_oe_n` low and `ram_we_n` high for at least ceil(30 ns / clock) cycles plus one capture cycle. `host_rdata` then equals the byte stored at the requested address and is valid while `host_done` is high.
- R3: `ram_we_n` is low only while `ram_sel_n` is 0 and `ram_sel` is 1. `ram_addr` does not change while `ram_we_n` is low, and stays at the accepted address for the whole access.
- R4: Each write-enable low pulse lasts max(ceil(22 ns), ceil(8 ns)+ceil(18 ns)) cycles, which is 6 cycles with a 5 ns clock.
- R5: `ram_dq_oe` rises only after `ram_we_n` has been low for ceil(8 ns / clock) cycles (2 at 5 ns). It is never high while `ram_we_n` is high, so never during a read, and it falls on the same cycle that `ram_we_n` rises.
- R6: Write data is driven for at least ceil(18 ns / clock) cycles (4 at 5 ns) before `ram_we_n` rises. The byte written is `host_wdata` as sampled at acceptance.
- R7: Between two accesses the RAM stays deselected for at least max(ceil(15 ns), ceil(8 ns)) cycles (3 at 5 ns). `host_ready` returns exactly that many cycles after `host_done`.
- R8: `host_done` is one cycle wide. Requests are accepted only while `host_ready` is high. A strobe while busy is dropped and has no effect on the RAM.
- R9: With a 5 ns clock, `host_done` appears 8 cycles after a read is accepted and 9 cycles after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, taken only when host_ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Controller idle and able to accept |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| ram_addr | output | 17 | RAM address lines |
| ram_sel_n | output | 1 | Low-true RAM select |
| ram_sel | output | 1 | High-true RAM select |
| ram_oe_n | output | 1 | Low-true RAM output enable |
| ram_we_n | output | 1 | Low-true RAM write enable |
| ram_dq_out | output | 8 | Data the controller drives onto the shared bus |
| ram_dq_oe | output | 1 | Enable for the controller's bus driver |
| ram_dq_in | input | 8 | Data sampled from the shared bus |

## Verification
The assertions assume that `host_req` is sampled only at clock edges. They also assume the host fields are meaningful only in the cycle of acceptance. The RAM model is assumed to drive `ram_dq_in` only while it is selected with its output enable low and its write enable high. The bench drives the strobe and fields on falling edges, keeps them for one cycle, and raises the strobe while busy only on purpose. Its RAM model follows the driving rule above, so the capture point and the write data seen at the write-enable rising edge depend only on the controller's timing.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_READ_WAIT  = 3'd1,
    ST_READ_CAPT  = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5,
    ST_TURNAROUND = 3'd6
  } asram_state_e;

  // Rounds a nanosecond minimum up to whole clocks; any nonzero minimum
  // costs at least one clock.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (ns > 0 && c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_dwell.sv
module asram_dwell #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_C    = 6,
  parameter int SETUP_C = 1,
  parameter int PULSE_C = 6,
  parameter int HZWE_C  = 2,
  parameter int RECOV_C = 1,
  parameter int TURN_C  = 3,
  parameter int CW      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic idle,
  output logic capture,
  output logic done,
  output logic sel_n,
  output logic sel,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam logic [CW-1:0] RD_L    = CW'(RD_C - 1);
  localparam logic [CW-1:0] SETUP_L = CW'(SETUP_C - 1);
  localparam logic [CW-1:0] PULSE_L = CW'(PULSE_C - 1);
  localparam logic [CW-1:0] RECOV_L = CW'(RECOV_C - 1);
  localparam logic [CW-1:0] TURN_L  = CW'(TURN_C - 1);
  localparam logic [CW-1:0] PULSE_N = CW'(PULSE_C);
  localparam logic [CW-1:0] HZWE_N  = CW'(HZWE_C);

  asram_state_e  state_q, state_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic [CW-1:0] cnt;
  logic          exp_w;

  asram_dwell #(.CW(CW)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .count    (cnt),
    .expired  (exp_w)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start) state_d = start_wr ? ST_WR_SETUP : ST_READ_WAIT;
      ST_READ_WAIT:  if (exp_w) state_d = ST_READ_CAPT;
      ST_READ_CAPT:  state_d = ST_TURNAROUND;
      ST_WR_SETUP:   if (exp_w) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (exp_w) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (exp_w) state_d = ST_TURNAROUND;
      ST_TURNAROUND: if (exp_w) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // dwell reload on every state change
  always_comb begin
    ld = (state_d != state_q);
    case (state_d)
      ST_READ_WAIT:  ld_val = RD_L;
      ST_WR_SETUP:   ld_val = SETUP_L;
      ST_WR_PULSE:   ld_val = PULSE_L;
      ST_WR_RECOVER: ld_val = RECOV_L;
      ST_TURNAROUND: ld_val = TURN_L;
      default:       ld_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // registered pin controls, decoded from the next state
  logic sel_act_d, oe_act_d, we_act_d, drv_d, done_d, capt_d;
  logic sel_act_q, oe_act_q, we_act_q, drv_q, done_q;

  always_comb begin
    sel_act_d = (state_d != ST_IDLE) && (state_d != ST_TURNAROUND);
    oe_act_d  = sel_act_d;
    we_act_d  = (state_d == ST_WR_PULSE);
    if (state_d != ST_WR_PULSE) begin
      drv_d = 1'b0;
    end else if (ld) begin
      drv_d = (HZWE_C == 0);
    end else begin
      drv_d = ((PULSE_N - cnt) >= HZWE_N);
    end
    capt_d = (state_q == ST_READ_CAPT);
    done_d = capt_d || ((state_q == ST_WR_RECOVER) && exp_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_act_q <= 1'b0;
      oe_act_q  <= 1'b0;
      we_act_q  <= 1'b0;
      drv_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sel_act_q <= sel_act_d;
      oe_act_q  <= oe_act_d;
      we_act_q  <= we_act_d;
      drv_q     <= drv_d;
      done_q    <= done_d;
    end
  end

  assign idle    = (state_q == ST_IDLE);
  assign capture = capt_d;
  assign done    = done_q;
  assign sel_n   = ~sel_act_q;
  assign sel     = sel_act_q;
  assign oe_n    = ~oe_act_q;
  assign we_n    = ~we_act_q;
  assign dq_oe   = drv_q;

  // run-length trackers for the timing properties
  logic [7:0] wl_q;
  logic [7:0] ds_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q <= '0;
      ds_q <= 8'hFF;
    end else begin
      wl_q <= we_n ? 8'd0 : ((wl_q == 8'hFF) ? wl_q : wl_q + 8'd1);
      ds_q <= (!sel_n) ? 8'd0 : ((ds_q == 8'hFF) ? ds_q : ds_q + 8'd1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sel_n && !sel && we_n && oe_n && !dq_oe && !done)); // R1
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!sel_n && sel)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (wl_q >= 8'(PULSE_C))); // R4
  AST_DRV_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n); // R5
  AST_DRV_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (wl_q >= 8'(HZWE_C))); // R5
  AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !dq_oe); // R5
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (ds_q >= 8'(TURN_C))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          idle,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_in;
    end
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rdata_out = rdata_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> ($stable(addr_q) && $stable(wdata_q))); // R3
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> idle); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int AW            = 17,
  parameter int DW            = 8,
  parameter int T_READ_CYC    = 30,
  parameter int T_ADDR_ACC    = 30,
  parameter int T_SEL_ACC     = 30,
  parameter int T_OE_ACC      = 12,
  parameter int T_WR_CYC      = 30,
  parameter int T_SEL_WEND    = 22,
  parameter int T_WE_WIDTH    = 22,
  parameter int T_DATA_SETUP  = 18,
  parameter int T_WE_FLOAT    = 8,
  parameter int T_SEL_FLOAT   = 15,
  parameter int T_OE_FLOAT    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int CK       = CLK_PERIOD_NS;
  localparam int RD_C     = imax(1, imax(ns2cyc(T_READ_CYC, CK),
                                  imax(ns2cyc(T_ADDR_ACC, CK),
                                  imax(ns2cyc(T_SEL_ACC, CK), ns2cyc(T_OE_ACC, CK)))));
  localparam int SETUP_C  = 1;
  localparam int HZWE_C   = ns2cyc(T_WE_FLOAT, CK);
  localparam int PULSE_C  = imax(1, imax(ns2cyc(T_WE_WIDTH, CK),
                                  imax(HZWE_C + ns2cyc(T_DATA_SETUP, CK),
                                       ns2cyc(T_SEL_WEND, CK) - SETUP_C)));
  localparam int RECOV_C  = imax(1, ns2cyc(T_WR_CYC, CK) - SETUP_C - PULSE_C);
  localparam int TURN_C   = imax(1, imax(ns2cyc(T_SEL_FLOAT, CK), ns2cyc(T_OE_FLOAT, CK)));
  localparam int CW       = $clog2(imax(RD_C, imax(PULSE_C, imax(RECOV_C, TURN_C))) + 2);

  logic idle;
  logic capture;
  logic accept;

  assign accept     = host_req && idle;
  assign host_ready = idle;

  asram_seq #(
    .RD_C    (RD_C),
    .SETUP_C (SETUP_C),
    .PULSE_C (PULSE_C),
    .HZWE_C  (HZWE_C),
    .RECOV_C (RECOV_C),
    .TURN_C  (TURN_C),
    .CW      (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (host_wr),
    .idle     (idle),
    .capture  (capture),
    .done     (host_done),
    .sel_n    (ram_sel_n),
    .sel      (ram_sel),
    .oe_n     (ram_oe_n),
    .we_n     (ram_we_n),
    .dq_oe    (ram_dq_oe)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .idle      (idle),
    .addr_in   (host_addr),
    .wdata_in  (host_wdata),
    .bus_in    (ram_dq_in),
    .addr_out  (ram_addr),
    .wdata_out (ram_dq_out),
    .rdata_out (host_rdata)
  );

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_oe_n && ram_we_n) |-> !ram_dq_oe); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (ram_sel_n && ram_we_n && !host_done)); // R1

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_wr;
  logic [16:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ready;
  logic        host_done;
  logic [7:0]  host_rdata;
  logic [16:0] ram_addr;
  logic        ram_sel_n;
  logic        ram_sel;
  logic        ram_oe_n;
  logic        ram_we_n;
  logic [7:0]  ram_dq_out;
  logic        ram_dq_oe;
  logic [7:0]  ram_dq_in;

  int checks = 0;
  int errors = 0;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .ram_addr(ram_addr),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // RAM model
  logic [7:0] mem [512];

  function automatic logic [8:0] midx(input logic [16:0] a);
    logic [9:0] s;
    s = {2'b00, a[7:0]} + {1'b0, a[16:8]};
    return s[8:0];
  endfunction

  always_comb begin
    if (!ram_sel_n && ram_sel && !ram_oe_n && ram_we_n) ram_dq_in = mem[midx(ram_addr)];
    else ram_dq_in = 8'h5A;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // port monitor: pulse widths, driver timing, turnaround gaps, RAM writes
  bit         p_we_n = 1'b1;
  bit         p_oe = 1'b0;
  bit         p_sel = 1'b0;
  bit         seen_access = 1'b0;
  int         wl = 0;
  int         drv = 0;
  int         gap = 0;
  logic [7:0] drv_data = 8'h00;
  logic [16:0] we_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_we_n && !ram_we_n) begin
        chk(!ram_sel_n && ram_sel, "R3 select during WE", {ram_sel_n, ram_sel}, 1);
        we_addr = ram_addr;
      end
      if (!p_oe && ram_dq_oe)
        chk(wl == 2, "R5 float wait", wl, 2);
      if (!p_we_n && ram_we_n) begin
        chk(wl == 6, "R4 WE width", wl, 6);
        chk(!ram_dq_oe && p_oe, "R5 release with WE", ram_dq_oe, 0);
        chk(drv >= 4, "R6 data setup", drv, 4);
        chk(ram_addr == we_addr, "R3 addr stable", ram_addr, we_addr);
        mem[midx(ram_addr)] = drv_data;
      end
      if (!p_sel && !ram_sel_n) begin
        if (seen_access) chk(gap >= 3, "R7 deselect gap", gap, 3);
        seen_access = 1'b1;
      end
      wl  = ram_we_n ? 0 : wl + 1;
      if (ram_dq_oe) begin
        drv = drv + 1;
        drv_data = ram_dq_out;
      end else if (ram_we_n) begin
        drv = 0;
      end
      gap = ram_sel_n ? gap + 1 : 0;
      p_we_n = ram_we_n;
      p_oe   = ram_dq_oe;
      p_sel  = !ram_sel_n;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, output int lat);
    int n;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_addr = '0; host_wdata = '0;
    n = 1;
    while (!host_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    lat = n;
  endtask

  task automatic after_done(input string tag);
    int n;
    @(negedge clk);
    chk(!host_done, "R8 done one cycle", host_done, 0);
    n = 1;
    while (!host_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R7 ready return", n, 3);
    chk(ram_sel_n && !ram_sel && ram_we_n && ram_oe_n && !ram_dq_oe,
        "R1 idle pins", {ram_sel_n, ram_sel, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
  endtask

  task automatic t_reset();
    chk(host_ready, "R1 ready", host_ready, 1);
    chk(ram_sel_n && !ram_sel && ram_we_n && ram_oe_n && !ram_dq_oe && !host_done,
        "R1 reset pins", {ram_sel_n, ram_sel, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    int lat;
    issue(1'b1, a, d, lat);
    chk(lat == 9, "R9 write latency", lat, 9);
    after_done("wr");
    chk(mem[midx(a)] == d, "R6 written byte", mem[midx(a)], d);
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
    int lat;
    int en;
    issue(1'b0, a, 8'h00, lat);
    chk(lat == 8, "R9 read latency", lat, 8);
    chk(host_rdata == exp, "R2 read data", host_rdata, exp);
    after_done("rd");
    en = 0;
  endtask

  task automatic t_read_controls();
    int lat;
    int en;
    mem[midx(17'h0A5C3)] = 8'h3C;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 17'h0A5C3;
    @(negedge clk);
    host_req = 1'b0;
    en = 0;
    lat = 1;
    while (!host_done && lat < 100) begin
      if (!ram_sel_n && ram_sel && !ram_oe_n && ram_we_n && !ram_dq_oe) en++;
      @(negedge clk);
      lat++;
    end
    chk(en == 7, "R2 read enable window", en, 7);
    chk(host_rdata == 8'h3C, "R2 read data window", host_rdata, 8'h3C);
    after_done("rdc");
  endtask

  task automatic t_busy_ignore();
    int n;
    mem[midx(17'h12340)] = 8'h77;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00123; host_wdata = 8'hC9;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_ready, "R8 busy not ready", host_ready, 0);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h12340; host_wdata = 8'hEE;
    @(negedge clk);
    host_req = 1'b0;
    n = 0;
    while (!host_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    after_done("busy");
    chk(mem[midx(17'h12340)] == 8'h77, "R8 dropped strobe", mem[midx(17'h12340)], 8'h77);
    chk(mem[midx(17'h00123)] == 8'hC9, "R6 first write kept", mem[midx(17'h00123)], 8'hC9);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(17'h00000, 8'hA1);
    t_read(17'h00000, 8'hA1);
    t_write(17'h1FFFF, 8'h5E);
    t_read(17'h1FFFF, 8'h5E);
    t_read(17'h00000, 8'hA1);
    t_write(17'h12340, 8'hFF);
    t_read(17'h12340, 8'hFF);
    t_read_controls();
    t_busy_ignore();
    t_write(17'h00123, 8'h00);
    t_read(17'h00123, 8'h00);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule